// File: doc/BRIEF.md
# Flash Byte-Program Sequencer

This block is a host-side controller that programs bytes into a command-driven flash device using a pulse-and-verify loop. The host supplies a start strobe, a base address, a block length and a data-source choice. The data source is either a host buffer, read through an index/data port, or a constant zero fill. For each byte, the sequencer writes the program command (40h). It then writes the target address and byte, which starts a program pulse, and waits a fixed number of cycles. Next it writes the verify command (C0h), waits again, reads the byte back and compares it with the expected value.

On a mismatch, the sequencer repeats the pulse. Each byte gets at most a parameterised number of attempts, 25 by default. The attempt count restarts for every byte, and the address moves on only after a verify match. When the last byte verifies, the sequencer writes the read command (00h), drops the program-voltage enable and pulses `done`. If a byte still mismatches after its final attempt, it drops program voltage at once and pulses `fail`.

The state machine has these states:
- IDLE
- VPP_ON, which raises program voltage for T_VPP cycles
- CMD_PGM
- PGM_DATA
- PULSE_WAIT
- CMD_VFY
- VFY_WAIT
- VFY_READ
- VFY_CMP
- CMD_READ
- DONE
- FAIL

Its transitions are:
- IDLE→VPP_ON on start.
- VPP_ON→CMD_PGM when the timer expires.
- CMD_PGM→PGM_DATA→PULSE_WAIT.
- PULSE_WAIT→CMD_VFY on timer expiry.
- CMD_VFY→VFY_WAIT.
- VFY_WAIT→VFY_READ on timer expiry.
- VFY_READ→VFY_CMP.
- VFY_CMP→CMD_PGM on a match that is not the last byte (advance), or on a mismatch below the cap (retry).
- VFY_CMP→CMD_READ on a match of the last byte.
- VFY_CMP→FAIL on a mismatch at the cap.
- CMD_READ→DONE.
- DONE→IDLE and FAIL→IDLE.

Top module: `flprog_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `fail`, `vpp_en`, `fl_wr` and `fl_rd` are all low.
- R2: `vpp_en` rises in the cycle after a start is accepted and stays high for exactly T_VPP cycles before the first flash write; no flash write occurs with `vpp_en` low except the final 00h.
- R3: Every program attempt is a 40h write followed in the very next cycle by a write carrying the byte address on `fl_addr` and the byte on `fl_wdata`; `fl_wr` and `fl_rd` are never high together.
- R4: The C0h verify write occurs exactly T_PULSE+1 cycles after the address/data write of the same attempt.
- R5: The `fl_rd` strobe occurs exactly T_VFY+1 cycles after the C0h write; `fl_rdata` is sampled in the cycle after `fl_rd` and compared with the expected byte.
- R6: A verify mismatch starts another attempt, up to MAX_TRY attempts for one byte; a byte that needs k ≤ MAX_TRY pulses gets exactly k.
- R7: The attempt count restarts for every byte, and the address advances only after a verify match.
- R8: A mismatch on attempt MAX_TRY ends the job: `fail` pulses for one cycle with `vpp_en` low, no 00h is written, and later bytes of the block are never pulsed.
- R9: After the last byte matches, 00h is written; in the next cycle `vpp_en` is low and `done` pulses for one cycle.
- R10: A job programs addresses base..base+len_m1 in ascending order; in buffer mode byte i of the block is `src_data` read at `src_idx` = i.
- R11: With `zero_fill` high every byte is programmed and verified as 00h, whatever `src_data` carries.
- R12: A match on attempt MAX_TRY counts as success, not failure.
- R13: A start strobe while `busy` is high is ignored: no address of the new request is touched and only one result is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, accepted only when idle |
| base_addr | input | ADDR_W | First flash address of the job |
| len_m1 | input | LEN_W | Number of bytes in the job minus one |
| zero_fill | input | 1 | 1: program 00h; 0: take bytes from the host buffer |
| src_idx | output | LEN_W | Index of the current byte within the block |
| src_data | input | 8 | Host buffer byte at `src_idx` |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| vpp_en | output | 1 | Program-voltage enable |
| fl_wr | output | 1 | Flash write strobe (one cycle per write) |
| fl_rd | output | 1 | Flash read strobe |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data or command |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_rd` |

## Verification
Two decisions can fall in the same compare cycle: the attempt cap is reached on the same verify that decides the outcome of the byte. This is provoked by a flash model that needs exactly MAX_TRY pulses on one address, so the match and the cap arrive together. The scoreboard expects success with MAX_TRY pulses. A second job needs MAX_TRY+1 pulses on a middle byte, so the cap and the mismatch coincide. That job must end in failure with later addresses untouched. A start pulsed mid-job checks that request acceptance and a running job do not interact.

// File: rtl/flprog_pkg.sv
package flprog_pkg;
    localparam logic [7:0] CMD_PROGRAM = 8'h40;
    localparam logic [7:0] CMD_VERIFY  = 8'hC0;
    localparam logic [7:0] CMD_READ    = 8'h00;

    typedef enum logic [3:0] {
        S_IDLE,
        S_VPP_ON,
        S_CMD_PGM,
        S_PGM_DATA,
        S_PULSE_WAIT,
        S_CMD_VFY,
        S_VFY_WAIT,
        S_VFY_READ,
        S_VFY_CMP,
        S_CMD_READ,
        S_DONE,
        S_FAIL
    } seq_state_t;
endpackage

// File: rtl/flprog_timer.sv
module flprog_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // Counting down only: after a non-load cycle the count never grows.
    p_timer_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/flprog_tries.sv
module flprog_tries #(
    parameter int MAX_TRY = 25,
    localparam int TW = $clog2(MAX_TRY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [TW-1:0] tries,
    output logic          at_cap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tries <= '0;
        else if (clr)    tries <= '0;
        else if (inc)    tries <= tries + 1'b1;
    end

    assign at_cap = (tries == TW'(MAX_TRY));

    p_tries_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TW'(MAX_TRY));
    p_no_inc_at_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        at_cap |-> !inc || clr);
endmodule

// File: rtl/flprog_addr.sv
module flprog_addr #(
    parameter int ADDR_W = 17,
    parameter int LEN_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  idx,
    output logic              last
);
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr  <= '0;
            idx   <= '0;
            len_q <= '0;
        end else if (load) begin
            addr  <= base;
            idx   <= '0;
            len_q <= len_m1;
        end else if (adv) begin
            addr  <= addr + 1'b1;
            idx   <= idx + 1'b1;
        end
    end

    assign last = (idx == len_q);

    p_idx_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> !last);
endmodule

// File: rtl/flprog_seq.sv
module flprog_seq
    import flprog_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int LEN_W   = 17,
    parameter int MAX_TRY = 25,
    parameter int T_VPP   = 250,
    parameter int T_PULSE = 2500,
    parameter int T_VFY   = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              zero_fill,
    output logic [LEN_W-1:0]  src_idx,
    input  logic [7:0]        src_data,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              vpp_en,
    output logic              fl_wr,
    output logic              fl_rd,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic [7:0]        fl_rdata
);
    localparam int T_MAX1 = (T_PULSE > T_VFY) ? T_PULSE : T_VFY;
    localparam int T_MAX  = (T_MAX1 > T_VPP) ? T_MAX1 : T_VPP;
    localparam int TMR_W  = $clog2(T_MAX + 1);
    localparam int TRY_W  = $clog2(MAX_TRY + 1);
    localparam int VC_W   = $clog2(T_VPP + 1);

    seq_state_t state, nxt;
    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             try_clr, try_inc, at_cap;
    logic [TRY_W-1:0] tries;
    logic             a_load, a_adv, last;
    logic [ADDR_W-1:0] cur_addr;
    logic [7:0]       exp_q;
    logic             zero_q;
    logic             accept, match;

    assign accept = (state == S_IDLE) && start;
    assign match  = (fl_rdata == exp_q);

    flprog_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .zero(tmr_zero)
    );

    flprog_tries #(.MAX_TRY(MAX_TRY)) u_tries (
        .clk(clk), .rst_n(rst_n), .clr(try_clr), .inc(try_inc),
        .tries(tries), .at_cap(at_cap)
    );

    flprog_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(a_load), .base(base_addr),
        .len_m1(len_m1), .adv(a_adv), .addr(cur_addr), .idx(src_idx),
        .last(last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Mode and expected byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_q <= 1'b0;
            exp_q  <= '0;
        end else begin
            if (accept)              zero_q <= zero_fill;
            if (state == S_CMD_PGM)  exp_q  <= zero_q ? 8'h00 : src_data;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:       if (start) nxt = S_VPP_ON;
            S_VPP_ON:     if (tmr_zero) nxt = S_CMD_PGM;
            S_CMD_PGM:    nxt = S_PGM_DATA;
            S_PGM_DATA:   nxt = S_PULSE_WAIT;
            S_PULSE_WAIT: if (tmr_zero) nxt = S_CMD_VFY;
            S_CMD_VFY:    nxt = S_VFY_WAIT;
            S_VFY_WAIT:   if (tmr_zero) nxt = S_VFY_READ;
            S_VFY_READ:   nxt = S_VFY_CMP;
            S_VFY_CMP: begin
                if (match)       nxt = last ? S_CMD_READ : S_CMD_PGM;
                else if (at_cap) nxt = S_FAIL;
                else             nxt = S_CMD_PGM;
            end
            S_CMD_READ:   nxt = S_DONE;
            S_DONE:       nxt = S_IDLE;
            S_FAIL:       nxt = S_IDLE;
            default:      nxt = S_IDLE;
        endcase
    end

    // Outputs and control strobes
    always_comb begin
        busy     = (state != S_IDLE);
        done     = (state == S_DONE);
        fail     = (state == S_FAIL);
        vpp_en   = 1'b0;
        fl_wr    = 1'b0;
        fl_rd    = 1'b0;
        fl_addr  = cur_addr;
        fl_wdata = CMD_READ;
        tmr_load = 1'b0;
        tmr_val  = '0;
        try_clr  = 1'b0;
        try_inc  = 1'b0;
        a_load   = 1'b0;
        a_adv    = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_VPP - 1);
                    try_clr  = 1'b1;
                    a_load   = 1'b1;
                end
            end
            S_VPP_ON:     vpp_en = 1'b1;
            S_CMD_PGM: begin
                vpp_en   = 1'b1;
                fl_wr    = 1'b1;
                fl_wdata = CMD_PROGRAM;
            end
            S_PGM_DATA: begin
                vpp_en   = 1'b1;
                fl_wr    = 1'b1;
                fl_wdata = exp_q;
                try_inc  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_PULSE - 1);
            end
            S_PULSE_WAIT: vpp_en = 1'b1;
            S_CMD_VFY: begin
                vpp_en   = 1'b1;
                fl_wr    = 1'b1;
                fl_wdata = CMD_VERIFY;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_VFY - 1);
            end
            S_VFY_WAIT:   vpp_en = 1'b1;
            S_VFY_READ: begin
                vpp_en = 1'b1;
                fl_rd  = 1'b1;
            end
            S_VFY_CMP: begin
                vpp_en = 1'b1;
                if (match && !last) begin
                    a_adv   = 1'b1;
                    try_clr = 1'b1;
                end
            end
            S_CMD_READ: begin
                vpp_en   = 1'b1;
                fl_wr    = 1'b1;
                fl_wdata = CMD_READ;
            end
            S_DONE, S_FAIL: ;
            default: ;
        endcase
    end

    // Support counter for assertions: cycles since vpp_en rose, saturating.
    logic [VC_W-1:0] vpp_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       vpp_cnt <= '0;
        else if (!vpp_en)                 vpp_cnt <= '0;
        else if (vpp_cnt != VC_W'(T_VPP)) vpp_cnt <= vpp_cnt + 1'b1;
    end

    p_vpp_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_wr |-> vpp_en && (vpp_cnt == VC_W'(T_VPP)));
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_wr && fl_rd));
    p_data_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_wr && fl_wdata == CMD_PROGRAM && state == S_CMD_PGM) |=> fl_wr);
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != S_VFY_CMP) |=> $stable(fl_addr));
    p_fail_vpp_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !vpp_en && !done);
    p_done_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(fl_wr) && $past(fl_wdata) == CMD_READ && !vpp_en);
endmodule

// File: tb/flprog_seq_bench.sv
module flprog_seq_bench;
    localparam int AW = 6;
    localparam int LW = 6;
    localparam int MAXT = 25;
    localparam int TV = 5;
    localparam int TP = 4;
    localparam int TF = 3;

    typedef struct {
        bit ok;
        int total;
    } result_t;

    logic clk = 0, rst_n = 0, start = 0, zero_fill = 0;
    logic [AW-1:0] base_addr = '0;
    logic [LW-1:0] len_m1 = '0, src_idx;
    logic [7:0] src_data, fl_wdata, fl_rdata;
    logic busy, done, fail, vpp_en, fl_wr, fl_rd;
    logic [AW-1:0] fl_addr;

    always #2 clk = ~clk;

    flprog_seq #(.ADDR_W(AW), .LEN_W(LW), .MAX_TRY(MAXT), .T_VPP(TV),
                 .T_PULSE(TP), .T_VFY(TF)) u_flprog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .len_m1(len_m1), .zero_fill(zero_fill), .src_idx(src_idx),
        .src_data(src_data), .busy(busy), .done(done), .fail(fail),
        .vpp_en(vpp_en), .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata));

    int checks = 0, fails = 0;
    task automatic chk(bit c, string tag, int act, int exp);
        checks++;
        if (!c) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Host buffer and flash model
    logic [7:0] hbuf [64];
    logic [7:0] mem  [64];
    int need [64];
    int hits [64];
    bit fm_armed = 0;
    assign src_data = hbuf[src_idx];

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i] = 8'hFF; need[i] = 1; hits[i] = 0; hbuf[i] = 8'h5A;
        end
        fl_rdata = 8'hFF;
    end

    always @(posedge clk) begin
        if (fl_wr) begin
            if (fm_armed) begin
                hits[fl_addr] = hits[fl_addr] + 1;
                if (hits[fl_addr] >= need[fl_addr]) mem[fl_addr] = fl_wdata;
                fm_armed = 0;
            end else if (fl_wdata == 8'h40) fm_armed = 1;
        end
        if (fl_rd) fl_rdata <= mem[fl_addr];
    end

    // Monitor / scoreboard
    result_t sbq[$];
    int cyc = 0, vpp_rise = 0, last_dw = 0, last_c0 = 0, last_wr = -10;
    logic [7:0] last_wd = 8'h00;
    int mon_pulses = 0, results = 0;
    bit mon_armed = 0, saw_read = 0, vprev = 0;
    int job_base = 0, job_len = 0;
    bit job_zero = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (vpp_en && !vprev) vpp_rise = cyc;
            if (fl_wr && fl_wdata != 8'h00 || fl_wr && mon_armed)
                chk(vpp_en && (cyc - vpp_rise) >= TV, "R2 vpp lead", cyc - vpp_rise, TV);
            if (fl_wr && mon_armed) begin
                mon_armed = 0;
                mon_pulses++;
                last_dw = cyc;
                chk(last_wr == cyc - 1 && last_wd == 8'h40, "R3 data after 40h", last_wr, cyc - 1);
                chk(int'(fl_addr) >= job_base && int'(fl_addr) <= job_base + job_len,
                    "R10 address in block", fl_addr, job_base);
                chk(fl_wdata == (job_zero ? 8'h00 : hbuf[int'(fl_addr) - job_base]),
                    "R10/R11 program byte", fl_wdata,
                    job_zero ? 0 : hbuf[int'(fl_addr) - job_base]);
            end else if (fl_wr && fl_wdata == 8'h40) begin
                mon_armed = 1;
            end else if (fl_wr && fl_wdata == 8'hC0) begin
                chk(cyc - last_dw == TP + 1, "R4 pulse wait", cyc - last_dw, TP + 1);
                last_c0 = cyc;
            end else if (fl_wr && fl_wdata == 8'h00) begin
                saw_read = 1;
            end
            if (fl_rd)
                chk(cyc - last_c0 == TF + 1, "R5 verify wait", cyc - last_c0, TF + 1);
            chk(!(fl_wr && fl_rd), "R3 strobe exclusive", fl_wr, 0);
            if (done || fail) begin
                result_t e;
                results++;
                chk(sbq.size() > 0, "R13 unexpected result", results, 1);
                if (sbq.size() > 0) begin
                    e = sbq.pop_front();
                    chk(done == e.ok, e.ok ? "R9 done expected" : "R8 fail expected", done, e.ok);
                    chk(mon_pulses == e.total, "R6 total pulses", mon_pulses, e.total);
                end
                chk(!vpp_en, "R8/R9 vpp off at result", vpp_en, 0);
                if (done)
                    chk(last_wr == cyc - 1 && last_wd == 8'h00, "R9 read cmd before done", last_wr, cyc - 1);
                if (fail)
                    chk(!saw_read, "R8 no read cmd on fail", saw_read, 0);
            end
            if (fl_wr) begin last_wr = cyc; last_wd = fl_wdata; end
        end
        vprev = vpp_en;
    end

    task automatic run_job(int base, int lm1, bit zf);
        result_t e;
        e.ok = 1; e.total = 0;
        for (int i = 0; i <= lm1; i++) begin
            int n = need[base + i];
            e.total += (n > MAXT) ? MAXT : n;
            if (n > MAXT) begin e.ok = 0; break; end
        end
        sbq.push_back(e);
        job_base = base; job_len = lm1; job_zero = zf;
        mon_pulses = 0; saw_read = 0; results = 0;
        @(posedge clk); #1;
        base_addr = AW'(base); len_m1 = LW'(lm1); zero_fill = zf; start = 1;
        @(posedge clk); #1;
        start = 0;
        while (busy) begin @(posedge clk); #1; end
        repeat (3) @(posedge clk);
        #1;
        chk(sbq.size() == 0, "R13 result count", sbq.size(), 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && !fail && !vpp_en && !fl_wr && !fl_rd, "R1 reset state",
            {busy, done, fail, vpp_en, fl_wr, fl_rd}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !vpp_en, "R1 idle after reset", busy, 0);

        // single byte from buffer
        hbuf[0] = 8'hA5; need[5] = 1;
        run_job(5, 0, 0);
        chk(mem[5] == 8'hA5, "R10 single byte", mem[5], 8'hA5);

        // block with retries
        hbuf[0] = 8'h11; hbuf[1] = 8'h22; hbuf[2] = 8'h33; hbuf[3] = 8'h44;
        need[10] = 1; need[11] = 3; need[12] = 2; need[13] = 1;
        run_job(10, 3, 0);
        for (int i = 0; i < 4; i++) begin
            chk(mem[10 + i] == hbuf[i], "R10 block data", mem[10 + i], hbuf[i]);
            chk(hits[10 + i] == need[10 + i], "R7 per-byte attempts", hits[10 + i], need[10 + i]);
        end

        // zero fill ignores buffer
        hbuf[0] = 8'h77; hbuf[1] = 8'h66; hbuf[2] = 8'h55;
        need[20] = 2; need[21] = 1; need[22] = 1;
        run_job(20, 2, 1);
        for (int i = 0; i < 3; i++)
            chk(mem[20 + i] == 8'h00, "R11 zero fill", mem[20 + i], 0);

        // match on final permitted attempt
        hbuf[0] = 8'h3C; need[30] = MAXT;
        run_job(30, 0, 0);
        chk(mem[30] == 8'h3C && hits[30] == MAXT, "R12 match at cap", hits[30], MAXT);

        // failure on a middle byte
        hbuf[0] = 8'h01; hbuf[1] = 8'h02; hbuf[2] = 8'h03;
        need[40] = 1; need[41] = MAXT + 1; need[42] = 1;
        run_job(40, 2, 0);
        chk(hits[41] == MAXT, "R6 attempt cap", hits[41], MAXT);
        chk(hits[42] == 0 && mem[42] == 8'hFF, "R8 later byte untouched", hits[42], 0);
        chk(mem[40] == 8'h01, "R7 earlier byte kept", mem[40], 1);

        // start while busy is ignored
        hbuf[0] = 8'h12; hbuf[1] = 8'h34; need[50] = 4; need[51] = 4;
        fork
            run_job(50, 1, 0);
            begin
                repeat (20) @(posedge clk);
                #1; base_addr = AW'(60); start = 1;
                @(posedge clk); #1; start = 0; base_addr = AW'(50);
            end
        join
        chk(hits[60] == 0 && mem[60] == 8'hFF, "R13 busy start ignored", hits[60], 0);
        chk(mem[50] == 8'h12 && mem[51] == 8'h34, "R13 running job intact", mem[51], 8'h34);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule